// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is an 18-bit first-in first-out buffer whose write port and read port each run on their own clock. Both enables are active low, and so is every status flag. The write side produces full, almost-full and half-full. The read side produces empty and almost-empty. Each pointer crosses into the other clock domain as a Gray code through a two-flop synchronizer, so a flag can lag the true fill level, but empty and full never clear early.

Two thresholds set the almost flags: an almost-empty offset and an almost-full offset. While the load input is low, the data ports reach these offsets instead of the storage array. Writes set the two offsets in turn, and reads return them in the same turn. A mode input chooses how the almost flags are formed. In one mode they are computed only from registers of their own clock domain. In the other they are a combinational function of both live pointers. A retransmit strobe on the read side rewinds the read pointer so that the buffered stream can be read again from the start. The depth is a power-of-two parameter from 64 to 4096 words.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: On a rising write-clock edge with wr_en_n low, load_n high and full_n high, din is stored as the newest word. When full_n is low, the write is dropped, and the stored contents and their order are unchanged.
- R2: On a rising read-clock edge with rd_en_n low, load_n high, retx_n high and empty_n high, dout takes the oldest unread word. Words come out in the order they were written.
- R3: A read attempted while empty_n is low leaves dout unchanged and consumes nothing.
- R4: empty_n is low whenever no unread word is held, and it is never high with zero words held. After a write, it goes high within three read-clock cycles.
- R5: full_n is low when DEPTH words are held, and it is never high with DEPTH words held.
- R6: While load_n is low, an enabled write-clock edge stores din[AW-1:0] (AW = log2 DEPTH) into an offset. The first such write sets the almost-empty offset, the next sets the almost-full offset, and the two alternate from then on. The storage array and the fill level are not touched.
- R7: While load_n is low, an enabled read-clock edge drives an offset, zero-extended, onto dout. The first such read returns the almost-empty offset, the next returns the almost-full offset, and the two alternate from then on.
- R8: With L words held, almost_empty_n is low exactly when L is at most the almost-empty offset. almost_full_n is low exactly when L is at least DEPTH minus the almost-full offset.
- R9: With sync_mode high, almost_empty_n depends only on read-domain registers and almost_full_n only on write-domain registers, so a change made from the other side shows up only after synchronization. With sync_mode low, both flags follow the live pointers combinationally and change right after the edge that moves a pointer.
- R10: half_full_n is low exactly when more than DEPTH/2 words are held.
- R11: A read-clock edge with retx_n low sets the read position back to the first word written since reset, leaves dout and the write side unchanged, and ignores any read on that edge. The following reads return the stream again from its first word.
- R12: Reset (rst_n low) empties the FIFO and sets both offsets to 7. After reset, empty_n and almost_empty_n are low, full_n, almost_full_n and half_full_n are high, and dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| load_n | input | 1 | Active-low select of the offset registers instead of the storage array |
| retx_n | input | 1 | Active-low retransmit strobe, sampled on rd_clk |
| sync_mode | input | 1 | 1: almost flags built from domain-local registers; 0: combinational |
| din | input | 18 | Write data or offset value |
| dout | output | 18 | Read data or offset readback |
| empty_n | output | 1 | Active-low empty, read domain |
| full_n | output | 1 | Active-low full, write domain |
| almost_empty_n | output | 1 | Active-low almost-empty |
| almost_full_n | output | 1 | Active-low almost-full |
| half_full_n | output | 1 | Active-low more-than-half-full, write domain |

## Verification
The hardest condition to reach from the ports is the moment the two forms of the almost flags disagree. That happens just after a pointer moves, before the synchronizers have passed the new value to the other domain. The bench first parks the fill level exactly on the almost-empty offset. It then moves the level by one word and samples almost_empty_n right after that edge in each mode, so it can see that the registered form still lags while the combinational form has already switched. The full and overflow corners come from a directed fill that runs one word past DEPTH and checks every flag at every level in both modes. A random phase then runs the writer fast against a reader that is first slow and then fast, which pushes the FIFO against both full and empty with the clocks drifting in phase.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int DATA_W  = 18;
  localparam int PTR_MAX = 13;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // fill level of a pointer pair that wraps at 2**pw
  function automatic ptr_t level(ptr_t w, ptr_t r, int pw);
    ptr_t mask;
    mask = (ptr_t'(1) << pw) - ptr_t'(1);
    return (w - r) & mask;
  endfunction

  function automatic logic is_ae(ptr_t lvl, ptr_t off);
    return lvl <= off;
  endfunction

  function automatic logic is_af(ptr_t lvl, ptr_t off, ptr_t depth);
    return (lvl + off) >= depth;
  endfunction

  function automatic logic is_half(ptr_t lvl, ptr_t depth);
    return lvl > (depth >> 1);
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
  parameter int DW    = 18,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          load_n,
  input  logic [AW-1:0] ld_val,
  input  logic [PW-1:0] rd_gray_s,
  output logic [PW-1:0] wr_bin,
  output logic [PW-1:0] wr_gray,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          full_n,
  output logic          af_sync_n,
  output logic          hf_n,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  logic          push;
  logic          ld_wr;
  logic          ld_sel;
  logic [PW-1:0] wr_bin_inc;
  ptr_t          rd_bin_x;
  ptr_t          lvl;

  always_comb begin
    rd_bin_x   = from_gray(ptr_t'(rd_gray_s));
    lvl        = level(ptr_t'(wr_bin), rd_bin_x, PW);
    full_n     = (lvl != ptr_t'(DEPTH));
    hf_n       = !is_half(lvl, ptr_t'(DEPTH));
    af_sync_n  = !is_af(lvl, ptr_t'(af_off), ptr_t'(DEPTH));
    push       = !wr_en_n && load_n && full_n;
    ld_wr      = !wr_en_n && !load_n;
    wr_bin_inc = wr_bin + PW'(1);
  end

  assign mem_we    = push;
  assign mem_waddr = wr_bin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else if (push) begin
      wr_bin  <= wr_bin_inc;
      wr_gray <= PW'(to_gray(ptr_t'(wr_bin_inc)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= AW'(7);
      af_off <= AW'(7);
      ld_sel <= 1'b0;
    end else if (ld_wr) begin
      if (!ld_sel) ae_off <= ld_val;
      else         af_off <= ld_val;
      ld_sel <= !ld_sel;
    end
  end

  // R1: a write attempted while full does not move the write pointer
  a_r1_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && load_n && !full_n) |=> $stable(wr_bin));

  // R5: the pointer sent across the boundary changes at most one bit per edge
  a_r5_gray_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R10: a full buffer is always more than half full
  a_r10_full_means_half: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !hf_n);
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          load_n,
  input  logic          retx_n,
  input  logic [PW-1:0] wr_gray_s,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] ae_off_w,
  input  logic [AW-1:0] af_off_w,
  output logic [PW-1:0] rd_bin,
  output logic [PW-1:0] rd_gray,
  output logic [AW-1:0] mem_raddr,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          ae_sync_n
);
  logic          pop;
  logic          ld_rd;
  logic          ld_sel;
  logic [PW-1:0] rd_bin_inc;
  logic [AW-1:0] ae_q1, ae_q2, af_q1, af_q2;
  ptr_t          wr_bin_x;
  ptr_t          lvl;

  always_comb begin
    wr_bin_x   = from_gray(ptr_t'(wr_gray_s));
    lvl        = level(wr_bin_x, ptr_t'(rd_bin), PW);
    empty_n    = (lvl != '0);
    ae_sync_n  = !is_ae(lvl, ptr_t'(ae_q2));
    pop        = !rd_en_n && load_n && retx_n && empty_n;
    ld_rd      = !rd_en_n && !load_n && retx_n;
    rd_bin_inc = rd_bin + PW'(1);
  end

  assign mem_raddr = rd_bin[AW-1:0];

  // offsets are quasi-static; bring them into this domain before use
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q1 <= AW'(7);
      ae_q2 <= AW'(7);
      af_q1 <= AW'(7);
      af_q2 <= AW'(7);
    end else begin
      ae_q1 <= ae_off_w;
      ae_q2 <= ae_q1;
      af_q1 <= af_off_w;
      af_q2 <= af_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      dout    <= '0;
      ld_sel  <= 1'b0;
    end else if (!retx_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (pop) begin
      rd_bin  <= rd_bin_inc;
      rd_gray <= PW'(to_gray(ptr_t'(rd_bin_inc)));
      dout    <= mem_rdata;
    end else if (ld_rd) begin
      dout   <= ld_sel ? DW'(af_q2) : DW'(ae_q2);
      ld_sel <= !ld_sel;
    end
  end

  // R3: a read against an empty buffer leaves the output alone
  a_r3_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && load_n && retx_n && !empty_n) |=> $stable(dout));

  // R8: an empty buffer is always within the almost-empty window
  a_r8_empty_inside_ae: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !ae_sync_n);

  // R11: a retransmit strobe rewinds the read position and keeps dout
  a_r11_retx_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    !retx_n |=> (rd_bin == '0) && $stable(dout));
endmodule

// File: rtl/dcf_pflag_fifo.sv
`timescale 1ns/1ps
module dcf_pflag_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = DATA_W
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          rd_en_n,
  input  logic          load_n,
  input  logic          retx_n,
  input  logic          sync_mode,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          almost_empty_n,
  output logic          almost_full_n,
  output logic          half_full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] wr_gray_s, rd_gray_s;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] ae_off, af_off;
  logic          af_sync_n, ae_sync_n;
  ptr_t          lvl_live;
  logic          ae_live_n, af_live_n;

  dcf_sync #(.W(PW)) u_wr2rd (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  dcf_sync #(.W(PW)) u_rd2wr (
    .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  dcf_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  dcf_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
    .ld_val(din[AW-1:0]), .rd_gray_s(rd_gray_s),
    .wr_bin(wr_bin), .wr_gray(wr_gray), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .full_n(full_n), .af_sync_n(af_sync_n), .hf_n(half_full_n),
    .ae_off(ae_off), .af_off(af_off)
  );

  dcf_rd_side #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .load_n(load_n),
    .retx_n(retx_n), .wr_gray_s(wr_gray_s), .mem_rdata(mem_rdata),
    .ae_off_w(ae_off), .af_off_w(af_off),
    .rd_bin(rd_bin), .rd_gray(rd_gray), .mem_raddr(mem_raddr),
    .dout(dout), .empty_n(empty_n), .ae_sync_n(ae_sync_n)
  );

  // live level from both raw pointers: the asynchronous flag form
  always_comb begin
    lvl_live  = level(ptr_t'(wr_bin), ptr_t'(rd_bin), PW);
    ae_live_n = !is_ae(lvl_live, ptr_t'(ae_off));
    af_live_n = !is_af(lvl_live, ptr_t'(af_off), ptr_t'(DEPTH));
  end

  assign almost_empty_n = sync_mode ? ae_sync_n : ae_live_n;
  assign almost_full_n  = sync_mode ? af_sync_n : af_live_n;

  // R9: in registered mode a full buffer always shows almost-full
  a_r9_sync_full_inside_af: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (sync_mode && !full_n) |-> !almost_full_n);
endmodule

// File: tb/dcf_pflag_fifo_test.sv
`timescale 1ns/1ps
module dcf_pflag_fifo_test;
  localparam int DEPTH = 64;
  localparam int DW    = 18;

  logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic          wr_en_n = 1'b1, rd_en_n = 1'b1, load_n = 1'b1, retx_n = 1'b1;
  logic          sync_mode = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          empty_n, full_n, almost_empty_n, almost_full_n, half_full_n;

  int total = 0, bad = 0;
  int wcnt = 0, rcnt = 0;
  int aeo = 7, afo = 7;
  bit wsel = 0;
  logic [DW-1:0] hist [0:4095];

  always #5    wr_clk = ~wr_clk;
  always #6.5  rd_clk = ~rd_clk;

  dcf_pflag_fifo #(.DEPTH(DEPTH), .DW(DW)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .load_n(load_n), .retx_n(retx_n),
    .sync_mode(sync_mode), .din(din), .dout(dout),
    .empty_n(empty_n), .full_n(full_n), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n), .half_full_n(half_full_n)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    #2;
  endtask

  // expected flag values restated from the requirements
  task automatic check_almost(input string tag);
    int lvl = wcnt - rcnt;
    check("R8", {tag, " almost_empty_n"}, 32'(almost_empty_n), (lvl > aeo) ? 1 : 0);
    check("R8", {tag, " almost_full_n"},  32'(almost_full_n),  ((DEPTH - lvl) > afo) ? 1 : 0);
  endtask

  task automatic check_flags(input string tag);
    int lvl = wcnt - rcnt;
    check("R4",  {tag, " empty_n"},     32'(empty_n),     (lvl != 0) ? 1 : 0);
    check("R5",  {tag, " full_n"},      32'(full_n),      (lvl < DEPTH) ? 1 : 0);
    check("R10", {tag, " half_full_n"}, 32'(half_full_n), (2 * lvl > DEPTH) ? 0 : 1);
    check_almost(tag);
  endtask

  task automatic wr_cycle(input bit en, input logic [DW-1:0] d);
    bit acc;
    @(negedge wr_clk);
    wr_en_n = !en; din = d;
    acc = en && full_n;
    if (full_n) check("R5", "full_n high below DEPTH", 32'((wcnt - rcnt) < DEPTH), 1);
    @(posedge wr_clk); #1;
    wr_en_n = 1'b1;
    if (acc) begin hist[wcnt & 4095] = d; wcnt++; end
  endtask

  task automatic rd_cycle(input bit en);
    bit ok;
    logic [DW-1:0] prev;
    @(negedge rd_clk);
    rd_en_n = !en;
    ok = en && empty_n;
    prev = dout;
    if (empty_n) check("R4", "empty_n high with data", 32'((wcnt - rcnt) > 0), 1);
    @(posedge rd_clk); #1;
    rd_en_n = 1'b1;
    if (ok) begin
      check("R2", "read data", 32'(dout), 32'(hist[rcnt & 4095]));
      rcnt++;
    end else if (en) begin
      check("R3", "dout held on empty read", 32'(dout), 32'(prev));
    end
  endtask

  task automatic ld_write(input int v);
    @(negedge wr_clk);
    load_n = 1'b0; wr_en_n = 1'b0; din = DW'(v);
    @(posedge wr_clk); #1;
    wr_en_n = 1'b1; load_n = 1'b1;
    if (!wsel) aeo = v; else afo = v;
    wsel = !wsel;
  endtask

  task automatic ld_read(input string req, input int exp);
    @(negedge rd_clk);
    load_n = 1'b0; rd_en_n = 1'b0;
    @(posedge rd_clk); #1;
    rd_en_n = 1'b1; load_n = 1'b1;
    check(req, "offset readback", 32'(dout), 32'(exp));
  endtask

  task automatic drain();
    int guard = 0;
    while (wcnt > rcnt && guard < 4 * DEPTH + 400) begin
      rd_cycle(1'b1);
      guard++;
    end
    settle();
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst_n = 1'b0;
    wcnt = 0; rcnt = 0; aeo = 7; afo = 7; wsel = 0;
    #23;
    rst_n = 1'b1;
    settle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge wr_clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));

    // R12: reset state
    #2;
    check("R12", "empty_n in reset", 32'(empty_n), 0);
    repeat (3) @(posedge wr_clk);
    #2 rst_n = 1'b1;
    settle();
    check("R12", "dout after reset", 32'(dout), 0);
    check("R12", "empty_n", 32'(empty_n), 0);
    check("R12", "full_n", 32'(full_n), 1);
    check("R12", "almost_empty_n", 32'(almost_empty_n), 0);
    check("R12", "almost_full_n", 32'(almost_full_n), 1);
    check("R12", "half_full_n", 32'(half_full_n), 1);
    ld_read("R12", 7);
    ld_read("R12", 7);

    // R6, R7: program offsets and read them back in turn
    ld_write(5);
    ld_write(10);
    settle();
    ld_read("R7", 5);
    ld_read("R7", 10);
    check("R6", "load writes leave buffer empty", 32'(empty_n), 0);

    // R3: read against empty
    rd_cycle(1'b1);

    // five words, then the R9 lag corner at level == almost-empty offset
    for (int i = 0; i < 5; i++) wr_cycle(1'b1, DW'($urandom));
    settle();
    check_flags("level5");
    sync_mode = 1'b1;
    wr_cycle(1'b1, DW'($urandom));
    check("R9", "registered ae lags the write", 32'(almost_empty_n), 0);
    settle();
    check("R9", "registered ae after sync", 32'(almost_empty_n), 1);
    sync_mode = 1'b0;
    rd_cycle(1'b1);
    check("R9", "live ae right after read", 32'(almost_empty_n), 0);
    wr_cycle(1'b1, DW'($urandom));
    check("R9", "live ae right after write", 32'(almost_empty_n), 1);
    sync_mode = 1'b1;
    drain();
    check_flags("drained");

    // directed fill, one word past DEPTH, every flag in both modes
    for (int i = 0; i <= DEPTH; i++) begin
      settle();
      check_flags("fill");
      sync_mode = 1'b0;
      #1;
      check_almost("fill live");
      sync_mode = 1'b1;
      wr_cycle(1'b1, DW'($urandom));
    end
    settle();
    check("R1", "write while full dropped", 32'(wcnt - rcnt), DEPTH);
    check_flags("full");
    drain();
    check_flags("after fill drain");

    // random traffic, reader slow then fast
    fork
      begin
        for (int i = 0; i < 2000; i++) wr_cycle(($urandom % 4) != 0, DW'($urandom));
      end
      begin
        for (int i = 0; i < 2600; i++) begin
          if (i < 1300) rd_cycle(($urandom % 4) == 0);
          else          rd_cycle(($urandom % 4) != 0);
        end
      end
    join
    settle();
    drain();
    check_flags("after random");

    // R12 again mid-run, then R11 retransmit
    do_reset();
    check("R12", "empty_n after second reset", 32'(empty_n), 0);
    ld_read("R12", 7);
    ld_read("R12", 7);
    for (int i = 0; i < 10; i++) wr_cycle(1'b1, DW'($urandom));
    settle();
    for (int i = 0; i < 4; i++) rd_cycle(1'b1);
    settle();
    begin
      logic [DW-1:0] held;
      @(negedge rd_clk);
      retx_n = 1'b0; rd_en_n = 1'b0;
      held = dout;
      @(posedge rd_clk); #1;
      retx_n = 1'b1; rd_en_n = 1'b1;
      check("R11", "dout kept on retransmit", 32'(dout), 32'(held));
    end
    rcnt = 0;
    settle();
    check_flags("R11 rewound");
    for (int i = 0; i < 10; i++) rd_cycle(1'b1);
    check("R11", "all replayed words read", 32'(rcnt), 10);
    settle();
    check("R11", "empty after replay", 32'(empty_n), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule